// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiply Unit

This unit multiplies two byte operands and returns a 16-bit product split into a high byte and a low byte. The high byte is meant for the upper register of a fixed register pair and the low byte for the lower one. A three-bit mode input selects the operation. The lower two bits choose how the operands are interpreted: both unsigned, both two's complement, or the first signed and the second unsigned. The top bit chooses the fractional form, which returns the product moved one place to the left.

Each result comes with two status bits: a carry taken from the top bit of the unshifted product, and a zero flag computed from the delivered result. No other status is produced. An operation is issued by raising `start` for one cycle with the operands and the mode. The result, the flags and a one-cycle `done` pulse appear a fixed two clock edges later. A new operation may be issued on every cycle. The outputs are registered and keep their values until the next `done`.

Top module: `fmul_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `done`, `res_hi`, `res_lo`, `flag_z` and `flag_c` all become 0.
- R2: With `mode[1:0]` = 2'b00, both operands are read as unsigned, and {`res_hi`,`res_lo`} is their 16-bit product when `mode[2]` = 0.
- R3: With `mode[1:0]` = 2'b01, both operands are read as two's complement, and the product is the 16-bit two's complement value.
- R4: With `mode[1:0]` = 2'b10, `opnd_a` is sign-extended and `opnd_b` is zero-extended before multiplying.
- R5: The code `mode[1:0]` = 2'b11 behaves exactly like 2'b00 (unsigned by unsigned).
- R6: With `mode[2]` = 1, the delivered result is the 16-bit product shifted left by one. Bit 0 is 0 and the product's bit 15 is dropped.
- R7: `flag_c` equals bit 15 of the unshifted 16-bit product, in every mode.
- R8: `flag_z` is 1 exactly when the delivered 16-bit result {`res_hi`,`res_lo`} is zero.
- R9: A `start` sampled at clock edge N gives a one-cycle `done` after edge N+2. Starts on consecutive cycles give one pulse each, in issue order.
- R10: `res_hi`, `res_lo`, `flag_z` and `flag_c` change only at the edge that raises `done`. Operand or mode activity with `start` low has no effect on them.
- R11: A reset at any edge while an operation is in flight cancels it: no `done` follows for that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue an operation this cycle |
| mode | input | 3 | [1:0] operand signedness, [2] fractional |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 8 | Product bits 15:8 |
| res_lo | output | 8 | Product bits 7:0 |
| flag_z | output | 1 | Result-is-zero flag |
| flag_c | output | 1 | Unshifted product bit 15 |

## Verification
The hardest case to reach from the ports is an operation that is overlapped or cut short. Several products are in the two-stage pipe at once, or a reset lands between issue and delivery, so that a stale stage could leak a result or drop one. The stimulus runs long back-to-back bursts of starts across all eight mode codes. It mixes in idle gaps during which the operands keep changing, and it issues an operation followed one cycle later by a single-cycle reset. The scoreboard then flags any `done` that has no matching queued item.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  // signedness selection carried in mode[1:0]
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_RSV = 2'b11
  } sgn_sel_e;

  localparam int MODE_W   = 3;
  localparam int FRAC_BIT = 2;

endpackage

// File: rtl/fmul_opnd_ext.sv
module fmul_opnd_ext #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic          sign_en,
  output logic [DW:0]   ext
);
  // one extra bit: a copy of the MSB for signed, zero for unsigned
  assign ext = {sign_en & val[DW-1], val};
endmodule

// File: rtl/fmul_prod_core.sv
module fmul_prod_core #(
  parameter int DW = 8
) (
  input  logic signed [DW:0]     mul_a,
  input  logic signed [DW:0]     mul_b,
  output logic        [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] wide_a;
  logic signed [PW-1:0] wide_b;
  logic signed [PW-1:0] wide_p;

  assign wide_a = PW'(mul_a);
  assign wide_b = PW'(mul_b);
  assign wide_p = wide_a * wide_b;
  assign prod   = wide_p;
endmodule

// File: rtl/fmul_post.sv
module fmul_post #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] prod,
  input  logic            frac,
  output logic [2*DW-1:0] res,
  output logic            zf,
  output logic            cf
);
  localparam int PW = 2 * DW;

  always_comb begin
    if (frac) res = {prod[PW-2:0], 1'b0};
    else      res = prod;
  end

  assign cf = prod[PW-1];
  assign zf = (res == '0);
endmodule

// File: rtl/fmul_unit.sv
module fmul_unit #(
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [fmul_pkg::MODE_W-1:0]  mode,
  input  logic [DW-1:0]                opnd_a,
  input  logic [DW-1:0]                opnd_b,
  output logic                         done,
  output logic [DW-1:0]                res_hi,
  output logic [DW-1:0]                res_lo,
  output logic                         flag_z,
  output logic                         flag_c
);
  import fmul_pkg::*;

  localparam int EW = DW + 1;
  localparam int PW = 2 * DW;
  localparam int NOP = 2;

  sgn_sel_e        sel;
  logic [NOP-1:0]  sign_vec;
  logic [DW-1:0]   op_in  [NOP];
  logic [EW-1:0]   op_ext [NOP];

  assign sel         = sgn_sel_e'(mode[1:0]);
  assign sign_vec[0] = (sel == SGN_SS) || (sel == SGN_SU);
  assign sign_vec[1] = (sel == SGN_SS);
  assign op_in[0]    = opnd_a;
  assign op_in[1]    = opnd_b;

  for (genvar g = 0; g < NOP; g++) begin : g_ext
    fmul_opnd_ext #(.DW(DW)) u_ext (
      .val     (op_in[g]),
      .sign_en (sign_vec[g]),
      .ext     (op_ext[g])
    );
  end

  // stage 1: extended operands
  logic           s1_valid;
  logic           s1_frac;
  logic [EW-1:0]  s1_op [NOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_frac  <= 1'b0;
      for (int i = 0; i < NOP; i++) s1_op[i] <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_frac <= mode[FRAC_BIT];
        for (int i = 0; i < NOP; i++) s1_op[i] <= op_ext[i];
      end
    end
  end

  logic [PW-1:0] prod;
  logic [PW-1:0] res;
  logic          zf;
  logic          cf;

  fmul_prod_core #(.DW(DW)) u_core (
    .mul_a (s1_op[0]),
    .mul_b (s1_op[1]),
    .prod  (prod)
  );

  fmul_post #(.DW(DW)) u_post (
    .prod (prod),
    .frac (s1_frac),
    .res  (res),
    .zf   (zf),
    .cf   (cf)
  );

  // stage 2: registered result and flags
  logic s2_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      s2_frac <= 1'b0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        res_hi  <= res[PW-1:DW];
        res_lo  <= res[DW-1:0];
        flag_z  <= zf;
        flag_c  <= cf;
        s2_frac <= s1_frac;
      end
    end
  end

  // R9: every accepted start yields done two edges later
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 done);

  // R9: done only traces back to a start
  p_origin_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));

  // R10: outputs hold outside done
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable({res_hi, res_lo, flag_z, flag_c}));

  // R6: fractional results always have a clear LSB
  p_frac_lsb_r6: assert property (@(posedge clk) disable iff (rst)
    (done && s2_frac) |-> !res_lo[0]);

  // R7: a zero result cannot carry a set product MSB
  p_zero_nocarry_r7: assert property (@(posedge clk) disable iff (rst)
    (done && flag_z) |-> !flag_c);

endmodule

// File: tb/sim_fmul_unit.sv
`timescale 1ns/1ps
module sim_fmul_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       done;
  logic [7:0] res_hi, res_lo;
  logic       flag_z, flag_c;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [17:0] exp_q [$];
  int          iss_q [$];
  string       tag_q [$];
  logic [17:0] last_exp = '0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  fmul_unit u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .flag_z(flag_z), .flag_c(flag_c)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [17:0] model(logic [7:0] a, logic [7:0] b, logic [2:0] m);
    int ia, ib, p;
    logic [15:0] p16, r;
    ia = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    ib = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = ia * ib;
    p16 = p[15:0];
    r = m[2] ? {p16[14:0], 1'b0} : p16;
    return {(r == 16'h0), p16[15], r};
  endfunction

  function automatic string tag_of(logic [2:0] m);
    string s;
    case (m[1:0])
      2'b00: s = "R2";
      2'b01: s = "R3";
      2'b10: s = "R4";
      default: s = "R5";
    endcase
    if (m[2]) s = {s, "/R6"};
    return {s, "/R7/R8"};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: drive at negedge, push expectation
  task automatic issue(logic [7:0] a, logic [7:0] b, logic [2:0] m);
    opnd_a = a; opnd_b = b; mode = m; start = 1'b1;
    exp_q.push_back(model(a, b, m));
    iss_q.push_back(cyc);
    tag_q.push_back(tag_of(m));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      opnd_a = 8'($urandom(seed)); seed = seed + 7;
      opnd_b = ~opnd_a; mode = 3'(i);
      @(negedge clk);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9/R11 unexpected done", 32'(done), 32'd0);
      end else begin
        logic [17:0] e;
        int is;
        string t;
        e = exp_q.pop_front();
        is = iss_q.pop_front();
        t = tag_q.pop_front();
        check({flag_z, flag_c, res_hi, res_lo} == e, t,
              32'({flag_z, flag_c, res_hi, res_lo}), 32'(e));
        check(cyc == is + 2, "R9 latency", 32'(cyc - is), 32'd2);
        last_exp = e;
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] corners [9][2];
    corners = '{'{8'h00,8'h00}, '{8'hFF,8'hFF}, '{8'h80,8'h80}, '{8'h7F,8'h80},
                '{8'h80,8'h7F}, '{8'h01,8'hFF}, '{8'hFF,8'h01}, '{8'h7F,8'h7F},
                '{8'h00,8'h80}};
    repeat (4) @(negedge clk);
    // R1: reset state
    check({done, res_hi, res_lo, flag_z, flag_c} == '0, "R1 reset",
          32'({done, res_hi, res_lo, flag_z, flag_c}), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners, all modes, back-to-back
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 9; k++)
        issue(corners[k][0], corners[k][1], 3'(m));
    idle(5);
    // R10: held outputs after idle activity with start low
    check({flag_z, flag_c, res_hi, res_lo} == last_exp, "R10 hold",
          32'({flag_z, flag_c, res_hi, res_lo}), 32'(last_exp));

    // R11: reset cancels in-flight operation
    issue(8'h12, 8'h34, 3'b000);
    void'(exp_q.pop_back()); void'(iss_q.pop_back()); void'(tag_q.pop_back());
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(4);
    check({done, res_hi, res_lo, flag_z, flag_c} == '0, "R11/R1 cancel",
          32'({done, res_hi, res_lo, flag_z, flag_c}), 32'd0);

    // pseudo-random bursts with gaps
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      issue(seed[23:16], seed[15:8], seed[6:4]);
      if (seed[31:29] == 3'b000) begin
        idle(3);
        check({flag_z, flag_c, res_hi, res_lo} == last_exp, "R10 hold",
              32'({flag_z, flag_c, res_hi, res_lo}), 32'(last_exp));
      end
    end
    idle(4);
    check(exp_q.size() == 0, "R9 missing done", 32'(exp_q.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule